// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit carries out one bit-test operation per request on an operand of 16, 32 or 64 bits. The operand is either a register value supplied on the request or a word in memory. The unit can test a bit, set it, clear it or invert it. It always returns the selected bit's value from before the operation as a carry flag. It also returns the resulting operand value. A register form raises a write-back strobe. A memory form writes the new word back through a simple request/ready port.

The bit offset comes from a register or from an immediate field. An immediate offset, and any offset applied to a register operand, only picks a bit inside the operand. A register offset on a memory operand is a signed bit number counted from the base address. Its low bits choose the bit inside a word. The rest chooses a signed word displacement, so that an offset can reach words above or below the base. A sequencer steps through idle, read, modify, write and done. It raises `done` for a single cycle when the flag and the result are ready.

Top module: `bitop_unit`

## Requirements
- R1: `carry` equals the selected bit of the operand as it was before the operation, for every operation code.
- R2: Operation code 0 (test) leaves the value unchanged, 1 (set) forces the selected bit to 1, 2 (reset) forces it to 0 and 3 (complement) inverts it. `result` carries the new value, and the bits above the operand size read as zero.
- R3: Size code 0, 1 or 2 selects 16, 32 or 64 bits. For a register operand the bit index is the offset masked to its low 4, 5 or 6 bits.
- R4: A memory operand with a register offset first sign-extends the offset from the operand size. Its low 4/5/6 bits give the bit index. The rest, divided by the width and rounded toward minus infinity, gives a signed word displacement.
- R5: The memory byte address is `base_addr` plus that displacement times 2, 4 or 8, taken modulo 2^ADDR_W.
- R6: With `imm_form` set, the index is the offset masked to the low 4/5/6 bits, and the address is `base_addr` itself, with no displacement even on a memory operand.
- R7: A modifying memory operation issues exactly one read and then exactly one write to the same address. The write carries the new value in its low bytes, and `mem_size` shows the operand size.
- R8: A test on a memory operand issues one read and no write.
- R9: A register operand never raises `mem_req`. `result_we` is high only during the `done` cycle of a register set, reset or complement.
- R10: `done` is a single-cycle pulse. A register operation raises it in the second cycle after the cycle in which `start` was sampled.
- R11: `start` and the request inputs are ignored while an operation is in progress. The operation in flight completes with its original inputs, and no extra `done` follows.
- R12: During and right after reset, `done`, `mem_req`, `result_we`, `carry` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| op | input | 2 | Operation: 0 test, 1 set, 2 reset, 3 complement |
| size | input | 2 | Operand size: 0 = 16, 1 = 32, 2 = 64 bits |
| mem_form | input | 1 | 1 = memory operand, 0 = register operand |
| imm_form | input | 1 | 1 = offset is an immediate |
| offset | input | DATA_W | Bit offset (register or immediate) |
| reg_value | input | DATA_W | Register operand value |
| base_addr | input | ADDR_W | Memory operand byte address |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_size | output | 2 | Access size, same code as `size` |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data, new value in the low bytes |
| mem_rdata | input | DATA_W | Read data, operand in the low bytes |
| mem_ready | input | 1 | Memory accepts or returns in this cycle |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Old value of the selected bit |
| result | output | DATA_W | New operand value, zero above the size |
| result_we | output | 1 | Register write-back strobe |

## Verification
The assertions assume that `mem_ready` is only high while `mem_req` is high, and that `size` never takes the unused code 3. The bench's memory model raises ready only on a pending request, with a latency of zero to three cycles, and every stimulus draws its size from 0 to 2. The assertions also assume that the memory returns data only for the address it was given. The bench model keeps a byte store and answers each read from the requested address.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    BOP_TEST = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_FLIP = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_32 = 2'd1,
    SZ_64 = 2'd2
  } bsz_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } bst_e;
endpackage

// File: rtl/bitop_decode.sv
// Offset decode: bit index and effective byte address.
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  bsz_e              size,
  input  logic [DATA_W-1:0] offset,
  input  logic              is_mem,
  input  logic              imm,
  input  logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] addr
);
  logic [2:0]        lw;     // log2 of operand width
  logic [DATA_W-1:0] sx;     // offset sign-extended from operand size
  logic [IDX_W-1:0]  lmask;

  always_comb begin
    case (size)
      SZ_16: begin
        lw = 3'd4;
        sx = {{(DATA_W-16){offset[15]}}, offset[15:0]};
      end
      SZ_32: begin
        lw = 3'd5;
        sx = {{(DATA_W-32){offset[31]}}, offset[31:0]};
      end
      default: begin
        lw = 3'd6;
        sx = offset;
      end
    endcase
    lmask = ~({IDX_W{1'b1}} << lw);
    index = offset[IDX_W-1:0] & lmask;
    if (is_mem && !imm)
      addr = base + ADDR_W'(($signed(sx) >>> lw) << (lw - 3'd3));
    else
      addr = base;
  end
endmodule

// File: rtl/bitop_alu.sv
// Selected-bit read and modify on a latched operand.
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  bop_e              op,
  input  bsz_e              size,
  input  logic [IDX_W-1:0]  index,
  input  logic [DATA_W-1:0] operand,
  output logic              old_bit,
  output logic [DATA_W-1:0] new_val
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] raw;

  always_comb begin
    sel = DATA_W'(1) << index;
    case (size)
      SZ_16:   wmask = DATA_W'(16'hFFFF);
      SZ_32:   wmask = DATA_W'(32'hFFFF_FFFF);
      default: wmask = '1;
    endcase
    old_bit = operand[index];
    case (op)
      BOP_SET:  raw = operand | sel;
      BOP_CLR:  raw = operand & ~sel;
      BOP_FLIP: raw = operand ^ sel;
      default:  raw = operand;
    endcase
    new_val = raw & wmask;
  end
endmodule

// File: rtl/bitop_seq.sv
// Sequencer: idle -> (read) -> modify -> (write) -> done.
module bitop_seq
  import bitop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_mem,
  input  logic modifies,
  input  logic mem_ready,
  output bst_e state,
  output logic accept,
  output logic rd_take,
  output logic mem_mode
);
  logic wr_q;

  assign accept  = start && (state == ST_IDLE);
  assign rd_take = (state == ST_READ) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_mode <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mem_mode <= is_mem;
          wr_q     <= modifies;
          state    <= is_mem ? ST_READ : ST_MODIFY;
        end
        ST_READ:   if (mem_ready) state <= ST_MODIFY;
        ST_MODIFY: state <= (mem_mode && wr_q) ? ST_WRITE : ST_DONE;
        ST_WRITE:  if (mem_ready) state <= ST_DONE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [1:0]        size,
  input  logic              mem_form,
  input  logic              imm_form,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] reg_value,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              done,
  output logic              carry,
  output logic [DATA_W-1:0] result,
  output logic              result_we
);
  localparam int IDX_W = $clog2(DATA_W);

  bst_e              state;
  logic              accept, rd_take, mem_mode;
  logic [IDX_W-1:0]  dec_index;
  logic [ADDR_W-1:0] dec_addr;
  bop_e              op_q;
  bsz_e              size_q;
  logic [IDX_W-1:0]  index_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] operand_q;
  logic              alu_old;
  logic [DATA_W-1:0] alu_new;
  logic              carry_q, wb_q;
  logic [DATA_W-1:0] result_q;

  bitop_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .is_mem(mem_form),
    .modifies(op != 2'd0), .mem_ready(mem_ready), .state(state),
    .accept(accept), .rd_take(rd_take), .mem_mode(mem_mode)
  );

  bitop_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .size(bsz_e'(size)), .offset(offset), .is_mem(mem_form), .imm(imm_form),
    .base(base_addr), .index(dec_index), .addr(dec_addr)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .size(size_q), .index(index_q), .operand(operand_q),
    .old_bit(alu_old), .new_val(alu_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= BOP_TEST;
      size_q    <= SZ_16;
      index_q   <= '0;
      addr_q    <= '0;
      operand_q <= '0;
      carry_q   <= 1'b0;
      result_q  <= '0;
      wb_q      <= 1'b0;
    end else begin
      if (accept) begin
        op_q      <= bop_e'(op);
        size_q    <= bsz_e'(size);
        index_q   <= dec_index;
        addr_q    <= dec_addr;
        operand_q <= reg_value;
      end
      if (rd_take) operand_q <= mem_rdata;
      if (state == ST_MODIFY) begin
        carry_q  <= alu_old;
        result_q <= alu_new;
        wb_q     <= !mem_mode && (op_q != BOP_TEST);
      end else if (state == ST_DONE) begin
        wb_q <= 1'b0;
      end
    end
  end

  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_size  = size_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = result_q;
  assign done      = (state == ST_DONE);
  assign carry     = carry_q;
  assign result    = result_q;
  assign result_we = wb_q;

  // R8: a test never reaches the write phase
  a_r8_test_no_write: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (op_q != BOP_TEST));
  // R7: address held from read through write
  a_r7_addr_held: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mem_addr));
  // R9: register operands stay off the memory port
  a_r9_reg_no_mem: assert property (@(posedge clk) disable iff (rst)
    !mem_mode |-> !mem_req);
  // R9: write-back strobe only alongside done
  a_r9_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    result_we |-> done);
  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11: latched request is frozen while busy
  a_r11_busy_frozen: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(op_q) && $stable(index_q) && $stable(size_q)));
  // R3: decoded index lies inside the operand
  a_r3_index_range: assert property (@(posedge clk) disable iff (rst)
    accept |-> (int'(dec_index) < (16 << int'(size))));
endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [1:0]  size = '0;
  logic        mem_form = 1'b0;
  logic        imm_form = 1'b0;
  logic [63:0] offset = '0;
  logic [63:0] reg_value = '0;
  logic [31:0] base_addr = '0;
  logic        mem_req, mem_we, done, carry, result_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, result;
  logic [63:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wcnt = 0;
  int nrd, nwr;
  logic [31:0] rd_addr, wr_addr;
  logic [63:0] wr_data;
  logic [1:0]  wr_size;
  bit [7:0] mem_b [bit [31:0]];
  longint cycles = 0;

  always #4 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .size(size),
    .mem_form(mem_form), .imm_form(imm_form), .offset(offset),
    .reg_value(reg_value), .base_addr(base_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .carry(carry), .result(result), .result_we(result_we)
  );

  function automatic logic [7:0] byte_at(logic [31:0] a);
    if (mem_b.exists(a)) return mem_b[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [63:0] mem_read(logic [31:0] a, int nb);
    logic [63:0] v = '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = byte_at(a + 32'(i));
    return v;
  endfunction

  // memory responder with programmable latency
  always @(negedge clk) begin
    cycles++;
    if (rst || !mem_req) begin
      mem_ready = 1'b0;
      wcnt = lat;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      wcnt = lat;
    end else if (wcnt > 0) begin
      wcnt--;
    end else begin
      mem_ready = 1'b1;
      if (mem_we) begin
        nwr++;
        wr_addr = mem_addr;
        wr_data = mem_wdata;
        wr_size = mem_size;
        for (int i = 0; i < (2 << mem_size); i++)
          mem_b[mem_addr + 32'(i)] = mem_wdata[8*i +: 8];
      end else begin
        nrd++;
        rd_addr = mem_addr;
        mem_rdata = mem_read(mem_addr, 2 << mem_size);
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int opc, input int sz, input bit mf, input bit imf,
                        input logic [63:0] off, input logic [63:0] rv,
                        input logic [31:0] base, input int lt, input bit inject,
                        input string tag);
    longint w = 64'sd16 << sz;
    longint so, d;
    logic [63:0] wm, oldv, nv, sel;
    logic [31:0] ea;
    int idx, cyc, nb;
    bit cf, modifies;
    nb = 2 << sz;
    wm = (sz == 2) ? '1 : ((64'd1 << w) - 64'd1);
    case (sz)
      0: so = {{48{off[15]}}, off[15:0]};
      1: so = {{32{off[31]}}, off[31:0]};
      default: so = off;
    endcase
    idx = int'(off & 64'(w - 1));
    d = 0;
    if (mf && !imf) begin
      d = so / w;
      if (so < 0 && (so % w) != 0) d = d - 1;
    end
    ea = base + 32'(d * (w / 8));
    oldv = mf ? mem_read(ea, nb) : (rv & wm);
    cf = oldv[idx];
    sel = 64'd1 << idx;
    case (opc)
      1: nv = oldv | sel;
      2: nv = oldv & ~sel;
      3: nv = oldv ^ sel;
      default: nv = oldv;
    endcase
    nv = nv & wm;
    modifies = (opc != 0);

    lat = lt; nrd = 0; nwr = 0;
    @(negedge clk);
    op = 2'(opc); size = 2'(sz); mem_form = mf; imm_form = imf;
    offset = off; reg_value = rv; base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      if (inject && cyc == 2) begin
        start = 1'b1; op = ~op; offset = ~off; mem_form = 1'b0; base_addr = ~base;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (cyc >= 200) begin
      errors++;
      $display("FAIL %s R10: actual no done expected done", tag);
      return;
    end
    chk({tag, " R1 carry"}, 64'(carry), 64'(cf));
    chk({tag, " R2 result"}, result, nv);
    chk({tag, " R9 result_we"}, 64'(result_we), 64'(!mf && modifies));
    chk({tag, " R7/R8 reads"}, 64'(nrd), mf ? 64'd1 : 64'd0);
    chk({tag, " R7/R8 writes"}, 64'(nwr), (mf && modifies) ? 64'd1 : 64'd0);
    if (!mf) chk({tag, " R10 latency"}, 64'(cyc), 64'd2);
    if (mf) begin
      chk({tag, imf ? " R6 address" : " R4/R5 address"}, 64'(rd_addr), 64'(ea));
      chk({tag, " R7 memory after"}, mem_read(ea, nb), modifies ? nv : oldv);
      if (modifies) begin
        chk({tag, " R7 write addr"}, 64'(wr_addr), 64'(ea));
        chk({tag, " R7 write data"}, wr_data & wm, nv);
        chk({tag, " R7 write size"}, 64'(wr_size), 64'(sz));
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({tag, " R10/R11 no extra done"}, 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset done", 64'(done), 64'd0);
    chk("R12 reset mem_req", 64'(mem_req), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 post-reset done", 64'(done), 64'd0);
    chk("R12 post-reset mem_req", 64'(mem_req), 64'd0);
    chk("R12 post-reset result_we", 64'(result_we), 64'd0);
    chk("R12 post-reset carry", 64'(carry), 64'd0);
    chk("R12 post-reset result", result, 64'd0);

    // register operands (R1 R2 R3 R9 R10)
    run_op(0, 1, 0, 0, 64'd5, 64'h20, 32'h0, 0, 0, "reg test32");
    run_op(1, 0, 0, 0, 64'h13, 64'h0, 32'h0, 0, 0, "R3 reg set16 masked");
    run_op(2, 2, 0, 0, 64'h7F, 64'h8000_0000_0000_0001, 32'h0, 0, 0, "R3 reg reset64");
    run_op(3, 1, 0, 0, 64'hFFFF_FFFF, 64'hAAAA_0000_0000_1234, 32'h0, 0, 0, "R2 reg flip32 upper");
    // memory with register offset (R4 R5 R7 R8)
    run_op(1, 0, 1, 0, 64'h25, 64'h0, 32'h1000, 1, 0, "R4 mem set16 fwd");
    run_op(0, 0, 1, 0, 64'hFFFF_FFFF_0000_FFF3, 64'h0, 32'h1000, 0, 0, "R4 mem test16 neg");
    run_op(2, 1, 1, 0, 64'hFFFF_FFFF, 64'h0, 32'h2000, 2, 0, "R5 mem reset32 neg");
    run_op(3, 2, 1, 0, 64'h1_0000_0042, 64'h0, 32'h3000, 0, 0, "R5 mem flip64 far");
    run_op(1, 2, 1, 0, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, 32'h3000, 1, 0, "R5 mem set64 neg");
    // immediate offsets (R6)
    run_op(3, 1, 1, 1, 64'h47, 64'h0, 32'h4000, 0, 0, "R6 imm flip32");
    run_op(0, 0, 1, 1, 64'hFF, 64'h0, 32'h4000, 0, 0, "R6 imm test16");
    run_op(2, 2, 0, 1, 64'hC1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 0, 0, "R6 imm reg reset64");
    // start while busy (R11)
    run_op(1, 1, 1, 0, 64'h3F, 64'h0, 32'h5000, 3, 1, "R11 busy start");
    run_op(3, 0, 0, 0, 64'h9, 64'h0, 32'h0, 0, 0, "R11 after ignore");
    // mixed traffic
    for (int n = 0; n < 60; n++) begin
      logic [63:0] ro, rv2;
      ro = {$urandom, $urandom};
      if (n % 3 == 0) ro = 64'($urandom % 200);
      rv2 = {$urandom, $urandom};
      run_op(int'($urandom % 4), int'($urandom % 3), 1'($urandom), 1'($urandom),
             ro, rv2, 32'h8000 + 32'($urandom % 4096), int'($urandom % 3), 0, "mix R1 R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule